// File: doc/BRIEF.md
# Single-Rate Token Bucket Policer

This block meters an ingress packet stream against one committed token bucket and returns, for every packet, a color and a pass/drop verdict. Tokens are held in bytes with a resolution of 1/256 byte. The refill amount, the bucket depth and the per-packet cost correction are each given as a floating encoding (1 + M/256) · 2^E. A slow internal tick, derived from the core clock by a parameterized prescaler and a power-of-two divider, adds the refill amount to the bucket. The bucket never grows beyond its depth.

A packet presents its length on a valid/ready interface. Its cost is the length less a configured offset, plus a signed adjustment. A length-mode bit drops the length term, so that every packet can be charged one token for packet-rate limiting. The meter is color-blind and its excess bucket is permanently disabled, so a packet is only green (conforming) or red. Each color has a 2-bit action code that the block turns into the drop flag. The verdict is held on a result port until the consumer takes it. An exponent of 23 is handled as 22.

Top module: `tok_policer`

## Requirements
- R1: In byte mode (len_mode_i = 0) a packet costs (max(len − offset, 0) bytes) + (adj_man − 256)/256 · 2^adj_exp bytes, with adj_man 9 bits wide.
- R2: A cost that works out to zero or less is raised to 1/256 byte.
- R3: With len_mode_i = 1 the length does not count; adj_man = 384 with adj_exp = 1 charges exactly one byte token per packet.
- R4: A packet is green and its cost is removed from the bucket when the bucket holds at least the cost; otherwise it is red and the bucket keeps its level.
- R5: Each refill adds (1 + rate_man/256) · 2^rate_exp bytes. With a steady divider it lands on the clock edges numbered k · CLKS_PER_UNIT · 2^rate_div (k ≥ 1), counted from reset release.
- R6: The bucket level saturates at the depth (1 + burst_man/256) · 2^burst_exp bytes.
- R7: The bucket is full right after reset. An exponent of 24 or more encodes zero, so such a bucket depth makes every packet red and such a refill adds nothing.
- R8: When a refill and an accepted packet fall on the same edge, the refill is applied before the packet is judged.
- R9: Colors are encoded green = 0, yellow = 1, red = 2, and yellow is never produced.
- R10: res_drop_o is 1 exactly when the action code of the packet's color is 2'b01; codes 00, 10 and 11 pass.
- R11: An accepted packet (pkt_valid_i and pkt_ready_o) gives a result on the next edge. The result stays stable while res_ready_i is low, and pkt_ready_o is low in that time, so no packet is charged.
- R12: During reset res_valid_o is 0 and pkt_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_exp_i | input | 5 | Refill exponent |
| rate_man_i | input | 8 | Refill mantissa |
| rate_div_i | input | RDIV_W | Refill interval divider, log2 of time units per refill |
| burst_exp_i | input | 5 | Bucket depth exponent |
| burst_man_i | input | 8 | Bucket depth mantissa |
| adj_exp_i | input | 5 | Cost adjustment exponent |
| adj_man_i | input | 9 | Cost adjustment mantissa |
| len_mode_i | input | 1 | 1: ignore packet length |
| len_off_i | input | OFF_W | Bytes subtracted from each length |
| act_green_i | input | 2 | Action code for green |
| act_yellow_i | input | 2 | Action code for yellow |
| act_red_i | input | 2 | Action code for red |
| pkt_valid_i | input | 1 | Packet present |
| pkt_ready_o | output | 1 | Packet can be accepted |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| res_valid_o | output | 1 | Verdict present |
| res_ready_i | input | 1 | Verdict taken |
| res_color_o | output | 2 | Verdict color |
| res_drop_o | output | 1 | Verdict drop flag |

## Verification
A vector table drains a bucket that gets no refill, using lengths just above, at and below the level. The cost is shaped by an offset, a negative adjustment and the one-token packet mode. This separates an off-by-one in the compare from a wrong cost formula, and it shows the 1/256 floor and the fractional remainder through the colors. The refill is then probed on edges one before and one after a scheduled tick, after a long idle that must stop at the depth, and on the tick edge itself. These runs catch a wrong interval, a missing saturation and the wrong order of refill and charge. Directed runs change the action codes, use a zero-size bucket and stall the result port while a second packet waits.

// File: rtl/tok_pol_pkg.sv
package tok_pol_pkg;
  localparam int FRAC_W   = 8;
  localparam int MAN_W    = 8;
  localparam int EXP_W    = 5;
  localparam int ZERO_EXP = 24;
  localparam int MAX_EXP  = 22;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } color_e;

  localparam logic [1:0] ACT_DROP = 2'b01;
endpackage

// File: rtl/tok_fp_decode.sv
module tok_fp_decode
  import tok_pol_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output logic [OUT_W-1:0] val_o
);
  logic [EXP_W-1:0] exp_c;

  // value in 1/256 units: (256 + man) << exp
  always_comb begin
    exp_c = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;
    if (exp_i >= EXP_W'(ZERO_EXP)) val_o = '0;
    else                           val_o = OUT_W'({1'b1, man_i}) << exp_c;
  end
endmodule

// File: rtl/tok_tick_gen.sv
module tok_tick_gen #(
  parameter int CLKS_PER_UNIT = 400,
  parameter int RDIV_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RDIV_W-1:0] div_i,
  output logic              tick_o
);
  localparam int PW = $clog2(CLKS_PER_UNIT + 1);
  localparam int DW = 2 ** RDIV_W;

  logic [PW-1:0] presc_q;
  logic [DW-1:0] div_q;
  logic [DW-1:0] lim;
  logic          unit;

  assign unit   = (presc_q == PW'(CLKS_PER_UNIT - 1));
  assign lim    = (DW'(1) << div_i) - DW'(1);
  assign tick_o = unit && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      div_q   <= '0;
    end else begin
      presc_q <= unit ? '0 : presc_q + PW'(1);
      if (unit) div_q <= tick_o ? '0 : div_q + DW'(1);
    end
  end
endmodule

// File: rtl/tok_cost_calc.sv
module tok_cost_calc
  import tok_pol_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int OFF_W       = 8,
  parameter int ADJ_EXP_MAX = 16,
  parameter int CW          = 28
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             len_mode_i,
  input  logic [EXP_W-1:0] adj_exp_i,
  input  logic [MAN_W:0]   adj_man_i,
  output logic [CW-1:0]    cost_o
);
  logic [LEN_W-1:0]     bytes;
  logic signed [9:0]    adj_base;
  logic [EXP_W-1:0]     ae_c;
  logic signed [CW-1:0] byte_u;
  logic signed [CW-1:0] adj_ext;
  logic signed [CW-1:0] adj_u;
  logic signed [CW-1:0] sum;

  always_comb begin
    bytes = '0;
    if (!len_mode_i && (len_i > LEN_W'(off_i))) bytes = len_i - LEN_W'(off_i);
    byte_u   = $signed(CW'({bytes, {FRAC_W{1'b0}}}));
    adj_base = $signed({1'b0, adj_man_i}) - 10'sd256;
    ae_c     = (adj_exp_i > EXP_W'(ADJ_EXP_MAX)) ? EXP_W'(ADJ_EXP_MAX) : adj_exp_i;
    adj_ext  = {{(CW-10){adj_base[9]}}, adj_base};
    adj_u    = adj_ext <<< ae_c;
    sum      = byte_u + adj_u;
    // floor at one fractional token
    if (sum[CW-1] || (sum == '0)) cost_o = CW'(1);
    else                          cost_o = $unsigned(sum);
  end
endmodule

// File: rtl/tok_bucket.sv
module tok_bucket #(
  parameter int LVL_W = 32,
  parameter int CW    = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [LVL_W-1:0] refill_i,
  input  logic [LVL_W-1:0] cap_i,
  input  logic             fire_i,
  input  logic [CW-1:0]    cost_i,
  output logic             fits_o
);
  localparam int CMP_W = ((LVL_W > CW) ? LVL_W : CW) + 1;

  logic [LVL_W-1:0] level_q, lvl_eff, lvl_ref, lvl_nxt;
  logic [LVL_W:0]   sum;

  always_comb begin
    // reset value all ones reads as "full" for any depth
    lvl_eff = (level_q < cap_i) ? level_q : cap_i;
    sum     = {1'b0, lvl_eff} + {1'b0, refill_i};
    if (tick_i) lvl_ref = (sum > {1'b0, cap_i}) ? cap_i : LVL_W'(sum);
    else        lvl_ref = lvl_eff;
    fits_o  = CMP_W'(lvl_ref) >= CMP_W'(cost_i);
    if (fire_i && fits_o) lvl_nxt = LVL_W'(CMP_W'(lvl_ref) - CMP_W'(cost_i));
    else                  lvl_nxt = lvl_ref;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '1;
    else         level_q <= lvl_nxt;
  end
endmodule

// File: rtl/tok_policer.sv
module tok_policer
  import tok_pol_pkg::*;
#(
  parameter int CLKS_PER_UNIT = 400,
  parameter int RDIV_W        = 4,
  parameter int LEN_W         = 16,
  parameter int OFF_W         = 8,
  parameter int LVL_W         = 32,
  parameter int ADJ_EXP_MAX   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        rate_exp_i,
  input  logic [7:0]        rate_man_i,
  input  logic [RDIV_W-1:0] rate_div_i,
  input  logic [4:0]        burst_exp_i,
  input  logic [7:0]        burst_man_i,
  input  logic [4:0]        adj_exp_i,
  input  logic [8:0]        adj_man_i,
  input  logic              len_mode_i,
  input  logic [OFF_W-1:0]  len_off_i,
  input  logic [1:0]        act_green_i,
  input  logic [1:0]        act_yellow_i,
  input  logic [1:0]        act_red_i,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [LEN_W-1:0]  pkt_len_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [1:0]        res_color_o,
  output logic              res_drop_o
);
  localparam int BYTE_UW = LEN_W + FRAC_W;
  localparam int ADJ_UW  = MAN_W + 2 + ADJ_EXP_MAX;
  localparam int CW      = ((BYTE_UW > ADJ_UW) ? BYTE_UW : ADJ_UW) + 2;

  logic             tick;
  logic [LVL_W-1:0] refill, cap;
  logic [CW-1:0]    cost;
  logic             fits, fire;
  color_e           nxt_col, col_q;
  logic [1:0]       act_sel;
  logic             valid_q, drop_q;

  tok_tick_gen #(.CLKS_PER_UNIT(CLKS_PER_UNIT), .RDIV_W(RDIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(rate_div_i), .tick_o(tick)
  );

  tok_fp_decode #(.OUT_W(LVL_W)) u_rate_dec (
    .exp_i(rate_exp_i), .man_i(rate_man_i), .val_o(refill)
  );

  tok_fp_decode #(.OUT_W(LVL_W)) u_burst_dec (
    .exp_i(burst_exp_i), .man_i(burst_man_i), .val_o(cap)
  );

  tok_cost_calc #(.LEN_W(LEN_W), .OFF_W(OFF_W), .ADJ_EXP_MAX(ADJ_EXP_MAX), .CW(CW)) u_cost (
    .len_i(pkt_len_i), .off_i(len_off_i), .len_mode_i(len_mode_i),
    .adj_exp_i(adj_exp_i), .adj_man_i(adj_man_i), .cost_o(cost)
  );

  tok_bucket #(.LVL_W(LVL_W), .CW(CW)) u_bucket (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .refill_i(refill), .cap_i(cap),
    .fire_i(fire), .cost_i(cost), .fits_o(fits)
  );

  assign pkt_ready_o = !valid_q || res_ready_i;
  assign fire        = pkt_valid_i && pkt_ready_o;

  always_comb begin
    nxt_col = fits ? COL_GREEN : COL_RED;
    unique case (nxt_col)
      COL_GREEN:  act_sel = act_green_i;
      COL_YELLOW: act_sel = act_yellow_i;
      default:    act_sel = act_red_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      col_q   <= COL_GREEN;
      drop_q  <= 1'b0;
    end else if (fire) begin
      valid_q <= 1'b1;
      col_q   <= nxt_col;
      drop_q  <= (act_sel == ACT_DROP);
    end else if (res_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign res_valid_o = valid_q;
  assign res_color_o = col_q;
  assign res_drop_o  = drop_q;
endmodule

// File: rtl/tok_policer_chk.sv
module tok_policer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pkt_valid_i,
  input logic       pkt_ready_o,
  input logic       res_valid_o,
  input logic       res_ready_i,
  input logic [1:0] res_color_o,
  input logic       res_drop_o,
  input logic [1:0] act_red_i
);
  // R9
  never_yellow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_color_o != 2'd1));

  // R11
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_color_o) && $stable(res_drop_o));

  // R11
  accept_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o |=> res_valid_o);

  // R10
  red_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o |=> (res_color_o != 2'd2) || (res_drop_o == ($past(act_red_i) == 2'b01)));
endmodule

bind tok_policer tok_policer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid_i), .pkt_ready_o(pkt_ready_o),
  .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_color_o(res_color_o),
  .res_drop_o(res_drop_o), .act_red_i(act_red_i)
);

// File: tb/tok_policer_tb.sv
`timescale 1ns/1ps
module tok_policer_tb;
  localparam int GREEN = 0;
  localparam int RED   = 2;

  // {rst, lmode, off[8], adj_man[9], adj_exp[5], len[16], green}
  localparam logic [40:0] VEC [12] = '{
    {1'b1, 1'b0, 8'd0,  9'd256, 5'd0, 16'd100,  1'b1}, // R1 level 1024 -> 924
    {1'b0, 1'b0, 8'd0,  9'd256, 5'd0, 16'd900,  1'b1}, // R4 -> 24
    {1'b0, 1'b0, 8'd0,  9'd256, 5'd0, 16'd25,   1'b0}, // R4 one above level
    {1'b0, 1'b0, 8'd0,  9'd256, 5'd0, 16'd24,   1'b1}, // R4 exact -> 0
    {1'b0, 1'b0, 8'd0,  9'd256, 5'd0, 16'd0,    1'b0}, // R2 cost 1/256 > 0
    {1'b1, 1'b0, 8'd20, 9'd128, 5'd2, 16'd120,  1'b1}, // R1 98 bytes -> 926
    {1'b0, 1'b0, 8'd20, 9'd128, 5'd2, 16'd10,   1'b1}, // R2 floor -> 926-1/256
    {1'b0, 1'b0, 8'd20, 9'd128, 5'd2, 16'd948,  1'b0}, // R1 926 > level
    {1'b0, 1'b0, 8'd20, 9'd128, 5'd2, 16'd947,  1'b1}, // R1 925 -> 255/256
    {1'b0, 1'b1, 8'd0,  9'd384, 5'd1, 16'd1500, 1'b0}, // R3 one token > 255/256
    {1'b1, 1'b1, 8'd0,  9'd384, 5'd1, 16'd9999, 1'b1}, // R3 -> 1023
    {1'b0, 1'b1, 8'd0,  9'd384, 5'd1, 16'd0,    1'b1}  // R3
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rate_exp = 5'd24, burst_exp = 5'd10, adj_exp = 5'd0;
  logic [7:0] rate_man = 8'd0, burst_man = 8'd0;
  logic [3:0] rate_div = 4'd0;
  logic [8:0] adj_man = 9'd256;
  logic       len_mode = 1'b0;
  logic [7:0] len_off = 8'd0;
  logic [1:0] act_g = 2'b00, act_y = 2'b00, act_r = 2'b01;
  logic       pkt_valid = 1'b0, res_ready = 1'b1;
  logic [15:0] pkt_len = '0;
  logic       pkt_ready, res_valid, res_drop;
  logic [1:0] res_color;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  tok_policer #(.CLKS_PER_UNIT(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rate_exp_i(rate_exp), .rate_man_i(rate_man), .rate_div_i(rate_div),
    .burst_exp_i(burst_exp), .burst_man_i(burst_man),
    .adj_exp_i(adj_exp), .adj_man_i(adj_man), .len_mode_i(len_mode), .len_off_i(len_off),
    .act_green_i(act_g), .act_yellow_i(act_y), .act_red_i(act_r),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_len_i(pkt_len),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_color_o(res_color), .res_drop_o(res_drop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 res_valid_o in reset", res_valid, 0);
    check("R12 pkt_ready_o in reset", pkt_ready, 1);
    rst_n = 1'b1;
  endtask

  // e > 0: packet is sampled on edge number e after reset release
  task automatic send(input int e, input logic [15:0] len, output logic [1:0] col, output logic drp);
    if (e > 0) while (cyc != e - 1) @(negedge clk);
    pkt_len   = len;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    col = res_color;
    drp = res_drop;
    check("R11 result valid after accept", res_valid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] col;
    logic       drp;

    // table: zero refill, depth 1024 bytes
    for (int i = 0; i < 12; i++) begin
      logic [40:0] v;
      v = VEC[i];
      len_mode = v[39];
      len_off  = v[38:31];
      adj_man  = v[30:22];
      adj_exp  = v[21:17];
      if (v[40]) do_reset();
      send(0, v[16:1], col, drp);
      check($sformatf("R4 table %0d color", i), col, v[0] ? GREEN : RED);
      check($sformatf("R10 table %0d drop", i), drp, v[0] ? 0 : 1);
    end
    len_mode = 1'b0; adj_man = 9'd256; adj_exp = 5'd0; len_off = 8'd0;

    // R5 R6 R8: 256 bytes every 8 edges (4 clocks/unit, divider 2)
    rate_exp = 5'd8; rate_div = 4'd1;
    do_reset();
    send(9, 16'd1024, col, drp);   check("R7 full after reset", col, GREEN);
    send(15, 16'd1, col, drp);     check("R5 no refill before edge 16", col, RED);
    send(17, 16'd256, col, drp);   check("R5 refill 256 at edge 16", col, GREEN);
    send(33, 16'd512, col, drp);   check("R5 two refills by edge 32", col, GREEN);
    send(100, 16'd1025, col, drp); check("R6 level capped at depth", col, RED);
    send(101, 16'd1024, col, drp); check("R6 depth available", col, GREEN);
    send(104, 16'd256, col, drp);  check("R8 refill before charge", col, GREEN);
    send(105, 16'd1, col, drp);    check("R8 refill consumed", col, RED);

    // R10 action codes
    rate_exp = 5'd24; rate_div = 4'd0;
    do_reset();
    act_r = 2'b00;
    send(0, 16'd5000, col, drp);
    check("R10 red pass color", col, RED);
    check("R10 red action 00 passes", drp, 0);
    act_g = 2'b01;
    send(0, 16'd10, col, drp);
    check("R10 green action 01 drops", drp, 1);
    act_g = 2'b10;
    send(0, 16'd10, col, drp);
    check("R10 green action 10 passes", drp, 0);
    act_g = 2'b00; act_r = 2'b01;

    // R7 zero-size bucket
    burst_exp = 5'd24;
    do_reset();
    send(0, 16'd0, col, drp);
    check("R7 zero depth gives red", col, RED);
    burst_exp = 5'd10;

    // R11 stalled result port
    do_reset();
    res_ready = 1'b0;
    send(0, 16'd2000, col, drp);
    check("R11 first verdict red", col, RED);
    pkt_len = 16'd1;
    pkt_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 ready low while stalled", pkt_ready, 0);
      check("R11 verdict held", res_color, RED);
      check("R9 never yellow", (res_color == 2'd1) ? 1 : 0, 0);
    end
    pkt_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    check("R11 verdict released", res_valid, 0);
    send(0, 16'd1024, col, drp);
    check("R11 stalled packet not charged", col, GREEN);

    finish_run();
  end
endmodule